// File: doc/BRIEF.md
# Segment LCD Drive Waveform Sequencer

This block steps a multiplexed segment LCD through its time slices and, in every half-period, tells each common and segment pin which drive rail it must carry. An external analog switch network turns each 3-bit level code into one of the rails VSS, VL1, VL2, VL3 or VL4. One pulse on the LCD clock tick input advances the sequence by one half-period. The registered outputs change only on such a tick.

The configuration is loaded with a strobe. It holds the number of time slices (static, 2, 3, 4 or 8), the bias ratio (1/2, 1/3 or 1/4) and the polarity scheme. With type A, each slot is split into two halves. With type B, every slot of the frame first shows its first-half levels, and then every slot shows its second-half levels. The level chosen for a pin depends on four things: whether the pin is a common or a segment, whether it is selected in the current slot, the bias, and the half. Because of this choice, the average voltage across each pixel is zero over a frame. A configuration that does not make sense is refused. The previous configuration stays active and an error flag is raised.

Each segment has one data byte. Bit k of that byte is the pixel state at common k.

Top module: `lcd_wave_seq`

## Requirements
- R1: After a synchronous reset, every level code is 0 (VSS), com_idx is 0 and cfg_err is 0. The active configuration is 4 slices, 1/3 bias, type A, and the sequence starts at slot 0, first half.
- R2: Level codes are 3 bits: 0=VSS, 1=VL1, 2=VL2, 3=VL3, 4=VL4. No other value ever appears. Outputs and com_idx change only on a clock edge where tick=1 and cfg_load=0.
- R3: Slots run 0,1,…,N-1 and then repeat, with only one common selected per slot. With type A (cfg_wave_b=0), each slot lasts two ticks, first half then second half. With type B (cfg_wave_b=1), the first N ticks show slots 0..N-1 in their first half and the next N ticks show slots 0..N-1 in their second half. com_idx shows the slot being driven.
- R4: A selected common drives VL4, then VSS. A selected segment (data bit 1) drives VSS, then VL4. A pixel sees the full swing only when both its common and its segment are selected.
- R5: The levels of non-selected pins, given as first half / second half, are as follows. At 1/2 bias, a common holds VL2 / VL2 and a segment drives VL4 / VSS. At 1/3 bias, a common drives VL1 / VL2 and a segment drives VL2 / VL1. At 1/4 bias, a common drives VL1 / VL3 and a segment holds VL2 / VL2.
- R6: With static duty (cfg_duty=0), all 8 commons carry VL4 / VSS. Each segment uses data bit 0: when the bit is 1 it drives VSS / VL4, and when it is 0 it drives VL4 / VSS.
- R7: Segment s takes its byte from seg_data[8s+7:8s]. In slot k the segment is selected when bit k of that byte is 1.
- R8: The duty codes are 1=2, 2=3, 3=4 and 4=8 slices. Common pins with an index of N or above stay at VSS. In static mode no common is unused.
- R9: Over each full frame of 2N ticks started from slot 0, the sum of the pixel voltage (common minus segment) is zero for every used common and every segment. In bias units the rails are: at 1/2 bias VL2=1 and VL4=2; at 1/3 bias VL1=1, VL2=2 and VL4=3; at 1/4 bias VLn=n.
- R10: On a tick with drive_en=0, all pins go to VSS and com_idx goes to 0. The sequence then restarts at slot 0, first half.
- R11: A legal configuration is applied in the cycle it is loaded. It clears cfg_err and restarts the sequence. A tick in a cycle with cfg_load=1 is ignored.
- R12: A load is illegal if the duty code is above 4, the bias code is 3, the duty is static with 1/4 bias, or the duty is 8 slices with 1/2 bias. An illegal load sets cfg_err and leaves the active configuration and the sequence unchanged. The bias codes are 0=1/2, 1=1/3 and 2=1/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | LCD clock tick, one half-period step |
| drive_en | input | 1 | Display enable; 0 forces VSS on the next tick |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_duty | input | 3 | Duty code |
| cfg_bias | input | 2 | Bias code |
| cfg_wave_b | input | 1 | 0 = type A, 1 = type B |
| seg_data | input | 8*NUM_SEG | One data byte per segment |
| com_lvl | output | 24 | Level code per common, pin i at bits [3i+2:3i] |
| seg_lvl | output | 3*NUM_SEG | Level code per segment, pin s at bits [3s+2:3s] |
| com_idx | output | 3 | Slot currently driven |
| cfg_err | output | 1 | Last configuration load was illegal |

## Verification
The bench checks every configuration against a bench model. The corner cases are the wrap of a type B frame into its second half, static mode, and unused commons. A design that confused type A with type B would keep the frame balanced but put the wrong level on a slot halfway through the frame. A design that picked the wrong level for a non-selected pin would leave a DC residue, and the per-frame pixel sums expose that. Illegal loads, loads that coincide with a tick, and a disable in the middle of a frame are also driven. An implementation that advanced on the load cycle, or kept its position after a disable, would come out one half-period off for the rest of the run.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int LVL_W    = 3;
  localparam int COM_PINS = 8;
  localparam int SLOT_W   = $clog2(COM_PINS);

  // Drive level codes
  localparam logic [LVL_W-1:0] LV_VSS = 3'd0;
  localparam logic [LVL_W-1:0] LV_1   = 3'd1;
  localparam logic [LVL_W-1:0] LV_2   = 3'd2;
  localparam logic [LVL_W-1:0] LV_3   = 3'd3;
  localparam logic [LVL_W-1:0] LV_4   = 3'd4;

  // Duty codes
  localparam logic [2:0] DUTY_STATIC = 3'd0;
  localparam logic [2:0] DUTY_2      = 3'd1;
  localparam logic [2:0] DUTY_3      = 3'd2;
  localparam logic [2:0] DUTY_4      = 3'd3;
  localparam logic [2:0] DUTY_8      = 3'd4;

  // Bias codes
  localparam logic [1:0] BIAS_HALF    = 2'd0;
  localparam logic [1:0] BIAS_THIRD   = 2'd1;
  localparam logic [1:0] BIAS_QUARTER = 2'd2;

  typedef struct packed {
    logic [2:0] duty;
    logic [1:0] bias;
    logic       wave_b;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{duty: DUTY_4, bias: BIAS_THIRD, wave_b: 1'b0};

  function automatic logic [3:0] slots_of(input logic [2:0] duty);
    case (duty)
      DUTY_2:  slots_of = 4'd2;
      DUTY_3:  slots_of = 4'd3;
      DUTY_4:  slots_of = 4'd4;
      DUTY_8:  slots_of = 4'd8;
      default: slots_of = 4'd1;
    endcase
  endfunction

  function automatic logic cfg_ok(input logic [2:0] duty, input logic [1:0] bias);
    logic ok;
    ok = (duty <= DUTY_8) && (bias <= BIAS_QUARTER);
    if (duty == DUTY_STATIC && bias == BIAS_QUARTER) ok = 1'b0;
    if (duty == DUTY_8 && bias == BIAS_HALF) ok = 1'b0;
    cfg_ok = ok;
  endfunction

endpackage

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] duty,
  input  logic [1:0] bias,
  input  logic       wave_b,
  output cfg_t       act,
  output logic       err,
  output logic       restart
);

  logic legal;

  assign legal   = cfg_ok(duty, bias);
  // A legal load restarts the sequence in the same edge it lands
  assign restart = load & legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= CFG_RESET;
      err <= 1'b0;
    end else if (load) begin
      if (legal) begin
        act <= '{duty: duty, bias: bias, wave_b: wave_b};
        err <= 1'b0;
      end else begin
        err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
  import lcd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              run,
  input  logic              restart,
  input  cfg_t              cfg,
  output logic [SLOT_W-1:0] slot,
  output logic              half
);

  logic [3:0]        nslots;
  logic [SLOT_W-1:0] last;
  logic              at_last;

  assign nslots  = slots_of(cfg.duty);
  assign last    = SLOT_W'(nslots - 4'd1);
  assign at_last = (slot == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      slot <= '0;
      half <= 1'b0;
    end else if (step) begin
      if (!run) begin
        slot <= '0;
        half <= 1'b0;
      end else if (!cfg.wave_b) begin
        // type A: both halves inside one slot
        if (!half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          slot <= at_last ? '0 : slot + 1'b1;
        end
      end else begin
        // type B: a full sweep per half of the frame
        if (at_last) begin
          slot <= '0;
          half <= ~half;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_pin_level.sv
module lcd_pin_level
  import lcd_seq_pkg::*;
#(
  parameter bit IS_COM = 1'b1
) (
  input  logic             sel,
  input  logic             half,
  input  logic             is_static,
  input  logic             used,
  input  logic [1:0]       bias,
  output logic [LVL_W-1:0] lvl
);

  generate
    if (IS_COM) begin : g_com
      always_comb begin
        if (!used) begin
          lvl = LV_VSS;
        end else if (sel) begin
          lvl = half ? LV_VSS : LV_4;
        end else begin
          case (bias)
            BIAS_HALF:  lvl = LV_2;
            BIAS_THIRD: lvl = half ? LV_2 : LV_1;
            default:    lvl = half ? LV_3 : LV_1;
          endcase
        end
      end
    end else begin : g_seg
      always_comb begin
        if (!used) begin
          lvl = LV_VSS;
        end else if (sel) begin
          lvl = half ? LV_4 : LV_VSS;
        end else if (is_static || bias == BIAS_HALF) begin
          lvl = half ? LV_VSS : LV_4;
        end else if (bias == BIAS_THIRD) begin
          lvl = half ? LV_1 : LV_2;
        end else begin
          lvl = LV_2;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          drive_en,
  input  logic                          cfg_load,
  input  logic [2:0]                    cfg_duty,
  input  logic [1:0]                    cfg_bias,
  input  logic                          cfg_wave_b,
  input  logic [COM_PINS*NUM_SEG-1:0]   seg_data,
  output logic [COM_PINS*LVL_W-1:0]     com_lvl,
  output logic [NUM_SEG*LVL_W-1:0]      seg_lvl,
  output logic [SLOT_W-1:0]             com_idx,
  output logic                          cfg_err
);

  localparam int BYTE_W = COM_PINS;

  cfg_t              act_cfg;
  logic              restart;
  logic              step;
  logic [SLOT_W-1:0] slot;
  logic              half;
  logic              is_static;
  logic [3:0]        nslots;

  logic [COM_PINS-1:0][LVL_W-1:0] com_nx, com_q;
  logic [NUM_SEG-1:0][LVL_W-1:0]  seg_nx, seg_q;

  // a load cycle never moves the sequence
  assign step = tick & ~cfg_load;

  lcd_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (cfg_load),
    .duty    (cfg_duty),
    .bias    (cfg_bias),
    .wave_b  (cfg_wave_b),
    .act     (act_cfg),
    .err     (cfg_err),
    .restart (restart)
  );

  lcd_slot_timer u_timer (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .run     (drive_en),
    .restart (restart),
    .cfg     (act_cfg),
    .slot    (slot),
    .half    (half)
  );

  assign is_static = (act_cfg.duty == DUTY_STATIC);
  assign nslots    = slots_of(act_cfg.duty);

  genvar gi;
  generate
    for (gi = 0; gi < COM_PINS; gi++) begin : g_com_pin
      lcd_pin_level #(.IS_COM(1'b1)) u_lvl (
        .sel       (is_static || (slot == SLOT_W'(gi))),
        .half      (half),
        .is_static (is_static),
        .used      (is_static || (4'(gi) < nslots)),
        .bias      (act_cfg.bias),
        .lvl       (com_nx[gi])
      );
    end

    for (gi = 0; gi < NUM_SEG; gi++) begin : g_seg_pin
      logic [BYTE_W-1:0] seg_byte;
      assign seg_byte = seg_data[gi*BYTE_W +: BYTE_W];
      lcd_pin_level #(.IS_COM(1'b0)) u_lvl (
        .sel       (seg_byte[slot]),
        .half      (half),
        .is_static (is_static),
        .used      (1'b1),
        .bias      (act_cfg.bias),
        .lvl       (seg_nx[gi])
      );
    end
  endgenerate

  // registered pin codes, refreshed only on a tick
  always_ff @(posedge clk) begin
    if (rst) begin
      com_q   <= '0;
      seg_q   <= '0;
      com_idx <= '0;
    end else if (step) begin
      if (drive_en) begin
        com_q   <= com_nx;
        seg_q   <= seg_nx;
        com_idx <= slot;
      end else begin
        com_q   <= '0;
        seg_q   <= '0;
        com_idx <= '0;
      end
    end
  end

  assign com_lvl = com_q;
  assign seg_lvl = seg_q;

endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tick,
  input logic                        drive_en,
  input logic                        cfg_load,
  input logic [2:0]                  cfg_duty,
  input logic [1:0]                  cfg_bias,
  input logic [COM_PINS*LVL_W-1:0]   com_lvl,
  input logic [NUM_SEG*LVL_W-1:0]    seg_lvl,
  input logic [SLOT_W-1:0]           com_idx,
  input logic                        cfg_err,
  input logic [2:0]                  act_duty
);

  logic [2:0]          shown_duty;
  logic [COM_PINS-1:0] vl4_mask;
  logic                unused_ok;
  logic                codes_ok;

  // duty in force when the displayed codes were captured
  always_ff @(posedge clk) begin
    if (rst) shown_duty <= DUTY_4;
    else if (tick && !cfg_load) shown_duty <= act_duty;
  end

  always_comb begin
    unused_ok = 1'b1;
    codes_ok  = 1'b1;
    for (int i = 0; i < COM_PINS; i++) begin
      vl4_mask[i] = (com_lvl[i*LVL_W +: LVL_W] == LV_4);
      if (com_lvl[i*LVL_W +: LVL_W] > LV_4) codes_ok = 1'b0;
      if (shown_duty != DUTY_STATIC && 4'(i) >= slots_of(shown_duty) &&
          com_lvl[i*LVL_W +: LVL_W] != LV_VSS) unused_ok = 1'b0;
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      if (seg_lvl[s*LVL_W +: LVL_W] > LV_4) codes_ok = 1'b0;
    end
  end

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && !cfg_load) |=> $stable(com_lvl) && $stable(seg_lvl) && $stable(com_idx));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst) codes_ok);

  // R3
  single_select_chk: assert property (@(posedge clk) disable iff (rst)
    shown_duty != DUTY_STATIC |-> $onehot0(vl4_mask));

  // R8
  unused_com_vss_chk: assert property (@(posedge clk) disable iff (rst) unused_ok);

  // R10
  disabled_vss_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !drive_en && !cfg_load |=> (com_lvl == '0) && (seg_lvl == '0) && (com_idx == '0));

  // R11
  good_cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && cfg_ok(cfg_duty, cfg_bias) |=> !cfg_err);

  // R12
  bad_cfg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && !cfg_ok(cfg_duty, cfg_bias) |=> cfg_err);

endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .drive_en   (drive_en),
  .cfg_load   (cfg_load),
  .cfg_duty   (cfg_duty),
  .cfg_bias   (cfg_bias),
  .com_lvl    (com_lvl),
  .seg_lvl    (seg_lvl),
  .com_idx    (com_idx),
  .cfg_err    (cfg_err),
  .act_duty   (act_cfg.duty)
);

// File: tb/lcd_wave_seq_tb.sv
module lcd_wave_seq_tb;

  localparam int NS  = 8;
  localparam int NC  = 8;
  localparam int LW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic drive_en = 1'b0;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_duty = 3'd3;
  logic [1:0] cfg_bias = 2'd1;
  logic cfg_wave_b = 1'b0;
  logic [NC*NS-1:0] seg_data = '0;
  logic [NC*LW-1:0] com_lvl;
  logic [NS*LW-1:0] seg_lvl;
  logic [2:0] com_idx;
  logic cfg_err;

  always #4 clk = ~clk;

  lcd_wave_seq #(.NUM_SEG(NS)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .drive_en(drive_en),
    .cfg_load(cfg_load), .cfg_duty(cfg_duty), .cfg_bias(cfg_bias),
    .cfg_wave_b(cfg_wave_b), .seg_data(seg_data),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .com_idx(com_idx), .cfg_err(cfg_err)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model
  int m_duty, m_bias, m_wb, m_err, m_p;
  int e_c [NC];
  int e_s [NS];
  int e_idx;

  function automatic int nsl(int d);
    case (d) 1: return 2; 2: return 3; 3: return 4; 4: return 8; default: return 1; endcase
  endfunction

  function automatic bit legal(int d, int b);
    if (d > 4 || b > 2) return 0;
    if (d == 0 && b == 2) return 0;
    if (d == 4 && b == 0) return 0;
    return 1;
  endfunction

  function automatic int lv_com(int i, int sl, int h);
    if (m_duty == 0) return h ? 0 : 4;
    if (i >= nsl(m_duty)) return 0;
    if (i == sl) return h ? 0 : 4;
    if (m_bias == 0) return 2;
    if (m_bias == 1) return h ? 2 : 1;
    return h ? 3 : 1;
  endfunction

  function automatic int lv_seg(bit b, int h);
    if (b) return h ? 4 : 0;
    if (m_duty == 0 || m_bias == 0) return h ? 0 : 4;
    if (m_bias == 1) return h ? 1 : 2;
    return 2;
  endfunction

  function automatic int volts(int code);
    if (m_duty == 0) return (code == 4) ? 1 : 0;
    if (m_bias == 0) return (code == 4) ? 2 : (code == 2 ? 1 : 0);
    if (m_bias == 1) return (code == 4) ? 3 : code;
    return code;
  endfunction

  task automatic model_reset();
    m_duty = 3; m_bias = 1; m_wb = 0; m_err = 0; m_p = 0; e_idx = 0;
    foreach (e_c[i]) e_c[i] = 0;
    foreach (e_s[i]) e_s[i] = 0;
  endtask

  task automatic model_edge();
    int n, sl, h;
    if (rst) begin
      model_reset();
    end else if (cfg_load) begin
      if (legal(cfg_duty, cfg_bias)) begin
        m_duty = cfg_duty; m_bias = cfg_bias; m_wb = cfg_wave_b; m_err = 0; m_p = 0;
      end else begin
        m_err = 1;
      end
    end else if (tick) begin
      if (!drive_en) begin
        foreach (e_c[i]) e_c[i] = 0;
        foreach (e_s[i]) e_s[i] = 0;
        e_idx = 0; m_p = 0;
      end else begin
        n = nsl(m_duty);
        if (m_wb != 0) begin sl = m_p % n; h = m_p / n; end
        else begin sl = m_p / 2; h = m_p % 2; end
        foreach (e_c[i]) e_c[i] = lv_com(i, sl, h);
        foreach (e_s[i]) e_s[i] = lv_seg(seg_data[i*NC + sl], h);
        e_idx = sl;
        m_p = (m_p + 1) % (2 * n);
      end
    end
  endtask

  task automatic cyc(input logic t, input logic l);
    tick = t; cfg_load = l;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    tick = 0; cfg_load = 0;
  endtask

  task automatic check_all(input string req);
    bit bad;
    bad = 0;
    n_checks++;
    for (int i = 0; i < NC; i++)
      if (!bad && int'(com_lvl[i*LW +: LW]) != e_c[i]) begin
        $display("FAIL %s com%0d level got %0d exp %0d", req, i, com_lvl[i*LW +: LW], e_c[i]);
        bad = 1;
      end
    for (int s = 0; s < NS; s++)
      if (!bad && int'(seg_lvl[s*LW +: LW]) != e_s[s]) begin
        $display("FAIL %s seg%0d level got %0d exp %0d", req, s, seg_lvl[s*LW +: LW], e_s[s]);
        bad = 1;
      end
    if (!bad && int'(com_idx) != e_idx) begin
      $display("FAIL %s com_idx got %0d exp %0d", req, com_idx, e_idx);
      bad = 1;
    end
    if (!bad && int'(cfg_err) != m_err) begin
      $display("FAIL %s cfg_err got %0d exp %0d", req, cfg_err, m_err);
      bad = 1;
    end
    if (bad) n_fail++;
  endtask

  task automatic set_cfg(input int d, input int b, input int w);
    cfg_duty = 3'(d); cfg_bias = 2'(b); cfg_wave_b = w[0];
  endtask

  // one full frame, checking order, levels, lit pixels (R4) and DC balance (R9)
  task automatic frame_run(input int d, input int b, input int w);
    int n, full, dv;
    int sum [NC][NS];
    bit lit_bad;
    set_cfg(d, b, w);
    cyc(0, 1);
    check_all("R11");
    seg_data = {$urandom, $urandom};
    drive_en = 1;
    n = nsl(d);
    full = volts(4);
    lit_bad = 0;
    foreach (sum[i, s]) sum[i][s] = 0;
    for (int k = 0; k < 2 * n; k++) begin
      cyc(1, 0);
      check_all(d == 0 ? "R6" : "R3/R5/R7/R8");
      for (int i = 0; i < n && i < NC; i++)
        for (int s = 0; s < NS; s++) begin
          dv = volts(int'(com_lvl[i*LW +: LW])) - volts(int'(seg_lvl[s*LW +: LW]));
          sum[i][s] += dv;
          if (((dv == full) || (dv == -full)) !=
              ((d == 0 || i == e_idx) && seg_data[s*NC + e_idx]))
            lit_bad = 1;
        end
    end
    n_checks++;
    if (lit_bad) begin
      n_fail++;
      $display("FAIL R4 lit pixel mismatch d=%0d b=%0d w=%0d got 1 exp 0", d, b, w);
    end
    n_checks++;
    for (int i = 0; i < n && i < NC; i++)
      for (int s = 0; s < NS; s++)
        if (sum[i][s] != 0 && !lit_bad) begin
          $display("FAIL R9 com%0d seg%0d frame sum got %0d exp 0", i, s, sum[i][s]);
          n_fail++;
          lit_bad = 1;
        end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    check_all("R1");

    // R1 default config: 4 slices, 1/3, type A, from slot 0 first half
    drive_en = 1;
    seg_data = 64'hA5;
    for (int k = 0; k < 8; k++) begin
      cyc(1, 0);
      check_all("R1");
    end

    // R2 no change without a tick
    for (int k = 0; k < 5; k++) begin
      seg_data = {$urandom, $urandom};
      cyc(0, 0);
      check_all("R2");
    end

    // every legal combination
    for (int d = 0; d <= 4; d++)
      for (int b = 0; b <= 2; b++)
        for (int w = 0; w <= 1; w++)
          if (legal(d, b)) frame_run(d, b, w);

    // R12 illegal loads keep old config running
    set_cfg(4, 2, 1); cyc(0, 1); check_all("R11");
    cyc(1, 0); cyc(1, 0);
    set_cfg(5, 1, 0); cyc(0, 1); check_all("R12");
    set_cfg(1, 3, 0); cyc(0, 1); check_all("R12");
    set_cfg(0, 2, 0); cyc(0, 1); check_all("R12");
    set_cfg(4, 0, 0); cyc(0, 1); check_all("R12");
    for (int k = 0; k < 6; k++) begin
      cyc(1, 0);
      check_all("R12");
    end

    // R11 load together with a tick: tick ignored, restart
    set_cfg(3, 2, 0); cyc(1, 1); check_all("R11");
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0);
      check_all("R11");
    end

    // R10 disable mid frame, then resume from slot 0
    drive_en = 0; cyc(1, 0); check_all("R10");
    drive_en = 1; cyc(1, 0); check_all("R10");
    cyc(1, 0); check_all("R10");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      tick = 1'b0;
      drive_en = ($urandom % 16) != 0;
      if (($urandom % 8) == 0) seg_data = {$urandom, $urandom};
      cfg_duty = 3'($urandom % 6);
      cfg_bias = 2'($urandom % 4);
      cfg_wave_b = 1'($urandom % 2);
      cyc(1'($urandom % 3 != 0), 1'($urandom % 40 == 0));
      check_all("R2/R3/R11/R12");
    end

    finish_run();
  end

endmodule